// File: doc/BRIEF.md
# Timestamp Target Time Comparator

This block watches a running time value, made of a seconds word and a nanoseconds word, and acts once that time reaches a target that software has programmed. The target is held in two bus-side registers. A command write copies them, together with an action mode, into the time-keeping clock domain. A busy flag stays set for as long as that copy is in flight, and writes to the target registers and the control register are dropped while it is set.

When the armed target is reached, the block does one of two things, or both, as the action mode selects. It can raise or lower a level pulse-run output in the time domain. It can also set a sticky interrupt status bit on the bus side. Each target fires once only. The match counts as reached as soon as the running time is at or past the target, so a counter that steps over the exact nanosecond value still triggers. The seconds are compared first. When the decimal rollover input is high, the block refuses nanosecond targets above 999,999,999.

Top module: `tgt_time_cmp`

## Requirements
- R1: The seconds target register is at address 0. The nanoseconds target register is at address 1. Both are read back over the bus. At address 1, bits 30:0 hold the nanoseconds, and bit 31 reads the busy flag and cannot be written.
- R2: A control write (address 2) whose bits 1:0 equal 2 (schedule start) or 3 (schedule stop) starts a transfer, and busy reads 1 from the next cycle until the transfer is acknowledged. Command values 0 and 1 start no transfer.
- R3: While busy is 1, writes to addresses 0, 1 and 2 are ignored.
- R4: An armed target fires when the running seconds are greater than the target seconds, or when they are equal and the running nanoseconds are greater than or equal to the target nanoseconds. It does not fire earlier.
- R5: Control bits 5:4 select the action on firing. 0 or 1 gives interrupt only, 2 gives interrupt plus pulse-run change, and 3 gives pulse-run change only. The status bit is set only when the mode includes the interrupt.
- R6: `pps_run` changes only on a firing whose mode includes the pulse action. It becomes 1 for a start command and 0 for a stop command.
- R7: A running time that jumps from below the target to a value past it in one step still fires.
- R8: Reset clears both target registers, the control register, the status bit, `irq` and `pps_run`.
- R9: After firing, the target stays disarmed until a new transfer completes. Later times past the target cause no further action.
- R10: Status bit 0 at address 3 is sticky. It is cleared by reading address 3, or by writing address 3 with bit 0 set. `irq` equals status AND control bit 8, one cycle later. A trigger event that arrives in the same cycle as a clear leaves the bit set.
- R11: When `roll_dec` is 1, a nanoseconds write with a value above 999,999,999 is ignored. When `roll_dec` is 0, it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Register interface clock |
| rst_bus | input | 1 | Synchronous active-high reset, bus domain |
| clk_ptp | input | 1 | Time-keeping clock |
| rst_ptp | input | 1 | Synchronous active-high reset, time domain |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered on a read strobe |
| roll_dec | input | 1 | Decimal nanosecond rollover mode, static |
| cur_sec | input | 32 | Running time, seconds (time domain) |
| cur_ns | input | 31 | Running time, nanoseconds (time domain) |
| pps_run | output | 1 | Pulse-run level, time domain |
| irq | output | 1 | Interrupt request, bus domain |

## Verification
A trigger event can cross into the bus domain in the same cycle in which software clears the status bit, whether by a read or by a write-one. The bench arms a target that has already been reached. It then holds a status read active on every bus cycle across the window in which the event lands. The test passes only if exactly one of those reads returns the bit set: a zero count means the clear swallowed the event, and a count above one means it was not cleared.

// File: rtl/tgt_pkg.sv
`timescale 1ns/1ps
package tgt_pkg;

  typedef enum logic [1:0] {
    A_SEC  = 2'd0,
    A_NSEC = 2'd1,
    A_CTRL = 2'd2,
    A_STAT = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    ACT_IRQ     = 2'd0,
    ACT_IRQ_ALT = 2'd1,
    ACT_BOTH    = 2'd2,
    ACT_PULSE   = 2'd3
  } act_e;

  localparam int unsigned DEC_NS_LIMIT = 999_999_999;

  function automatic logic act_has_irq(input act_e m);
    return m != ACT_PULSE;
  endfunction

  function automatic logic act_has_pulse(input act_e m);
    return (m == ACT_BOTH) || (m == ACT_PULSE);
  endfunction

endpackage

// File: rtl/tgt_sync.sv
`timescale 1ns/1ps
module tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/tgt_regs.sv
`timescale 1ns/1ps
module tgt_regs
  import tgt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              roll_dec,
  input  logic              ack_s,
  input  logic              evt_s,
  output logic [DATA_W-1:0] tgt_sec,
  output logic [DATA_W-2:0] tgt_ns,
  output logic              stop_q,
  output act_e              mode_q,
  output logic              req_tgl,
  output logic              irq
);
  localparam int NS_W = DATA_W - 1;
  localparam logic [NS_W-1:0] NS_LIM = NS_W'(DEC_NS_LIMIT);

  logic busy, irq_en, sts, evt_d, evt_pulse;
  logic wr_sec, wr_ns, wr_ctl, launch, clr, ns_ok;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    busy      = req_tgl ^ ack_s;
    ns_ok     = !roll_dec || (wdata[NS_W-1:0] <= NS_LIM);
    wr_sec    = we && (addr == A_SEC)  && !busy;
    wr_ns     = we && (addr == A_NSEC) && !busy && ns_ok;
    wr_ctl    = we && (addr == A_CTRL) && !busy;
    launch    = wr_ctl && wdata[1];
    evt_pulse = evt_s ^ evt_d;
    clr       = (re && (addr == A_STAT)) || (we && (addr == A_STAT) && wdata[0]);
  end

  always_comb begin
    case (addr)
      A_SEC:   rd_mux = tgt_sec;
      A_NSEC:  rd_mux = {busy, tgt_ns};
      A_CTRL:  rd_mux = DATA_W'({irq_en, 2'b00, mode_q, 4'b0000});
      default: rd_mux = DATA_W'(sts);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_sec <= '0;
      tgt_ns  <= '0;
      mode_q  <= ACT_IRQ;
      irq_en  <= 1'b0;
      stop_q  <= 1'b0;
      req_tgl <= 1'b0;
      evt_d   <= 1'b0;
      sts     <= 1'b0;
      irq     <= 1'b0;
      rdata   <= '0;
    end else begin
      if (wr_sec) tgt_sec <= wdata;
      if (wr_ns)  tgt_ns  <= wdata[NS_W-1:0];
      if (wr_ctl) begin
        mode_q <= act_e'(wdata[5:4]);
        irq_en <= wdata[8];
        if (launch) stop_q <= wdata[0];
      end
      req_tgl <= req_tgl ^ launch;
      evt_d   <= evt_s;
      sts     <= evt_pulse | (sts & ~clr);
      irq     <= sts & irq_en;
      if (re) rdata <= rd_mux;
    end
  end

  p_reset_clears_r8: assert property (@(posedge clk)
    rst |=> (tgt_sec == '0 && tgt_ns == '0 && !irq && !sts));

  p_busy_locks_ns_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && we && addr == A_NSEC) |=> $stable(tgt_ns));

  p_busy_locks_sec_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && we && addr == A_SEC) |=> $stable(tgt_sec));

  p_busy_cause_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(we && addr == A_CTRL && wdata[1]));

  p_dec_limit_r11: assert property (@(posedge clk) disable iff (rst)
    (roll_dec && we && addr == A_NSEC && wdata[NS_W-1:0] > NS_LIM) |=> $stable(tgt_ns));

  p_event_wins_r10: assert property (@(posedge clk) disable iff (rst)
    evt_pulse |=> sts);
endmodule

// File: rtl/tgt_match.sv
`timescale 1ns/1ps
module tgt_match
  import tgt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_s,
  input  logic [DATA_W-1:0] tgt_sec,
  input  logic [DATA_W-2:0] tgt_ns,
  input  logic              stop_in,
  input  act_e              mode_in,
  input  logic [DATA_W-1:0] cur_sec,
  input  logic [DATA_W-2:0] cur_ns,
  output logic              ack_tgl,
  output logic              evt_tgl,
  output logic              pps_run
);
  logic              req_d, new_req, armed, stop_q;
  logic              sec_gt, sec_eq, ns_ge, hit, fire;
  act_e              mode_q;
  logic [DATA_W-1:0] sec_q;
  logic [DATA_W-2:0] ns_q;

  always_comb begin
    new_req = req_s ^ req_d;
    sec_gt  = cur_sec > sec_q;
    sec_eq  = cur_sec == sec_q;
    ns_ge   = cur_ns >= ns_q;
    hit     = sec_gt || (sec_eq && ns_ge);
    fire    = armed && hit && !new_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_d   <= 1'b0;
      armed   <= 1'b0;
      stop_q  <= 1'b0;
      mode_q  <= ACT_IRQ;
      sec_q   <= '0;
      ns_q    <= '0;
      ack_tgl <= 1'b0;
      evt_tgl <= 1'b0;
      pps_run <= 1'b0;
    end else begin
      req_d <= req_s;
      if (new_req) begin
        sec_q   <= tgt_sec;
        ns_q    <= tgt_ns;
        stop_q  <= stop_in;
        mode_q  <= mode_in;
        armed   <= 1'b1;
        ack_tgl <= ~ack_tgl;
      end else if (fire) begin
        armed <= 1'b0;
        if (act_has_irq(mode_q))   evt_tgl <= ~evt_tgl;
        if (act_has_pulse(mode_q)) pps_run <= ~stop_q;
      end
    end
  end

  p_one_shot_r9: assert property (@(posedge clk) disable iff (rst)
    fire |=> !armed);

  p_pulse_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(pps_run));

  p_pulse_only_r5: assert property (@(posedge clk) disable iff (rst)
    (fire && mode_q == ACT_PULSE) |=> $stable(evt_tgl));

  p_not_reached_r4: assert property (@(posedge clk) disable iff (rst)
    (armed && !hit) |=> ($stable(evt_tgl) && $stable(pps_run)));
endmodule

// File: rtl/tgt_time_cmp.sv
`timescale 1ns/1ps
module tgt_time_cmp
  import tgt_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_bus,
  input  logic              rst_bus,
  input  logic              clk_ptp,
  input  logic              rst_ptp,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              roll_dec,
  input  logic [DATA_W-1:0] cur_sec,
  input  logic [DATA_W-2:0] cur_ns,
  output logic              pps_run,
  output logic              irq
);
  logic [DATA_W-1:0] tgt_sec;
  logic [DATA_W-2:0] tgt_ns;
  logic              stop_q, req_tgl, req_s, ack_tgl, ack_s, evt_tgl, evt_s;
  act_e              mode_q;

  tgt_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk_bus), .rst(rst_bus), .we(bus_we), .re(bus_re), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .roll_dec(roll_dec),
    .ack_s(ack_s), .evt_s(evt_s), .tgt_sec(tgt_sec), .tgt_ns(tgt_ns),
    .stop_q(stop_q), .mode_q(mode_q), .req_tgl(req_tgl), .irq(irq)
  );

  tgt_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk_ptp), .rst(rst_ptp), .d(req_tgl), .q(req_s)
  );

  tgt_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk_bus), .rst(rst_bus), .d(ack_tgl), .q(ack_s)
  );

  tgt_sync #(.STAGES(SYNC_STAGES)) u_evt_sync (
    .clk(clk_bus), .rst(rst_bus), .d(evt_tgl), .q(evt_s)
  );

  tgt_match #(.DATA_W(DATA_W)) u_match (
    .clk(clk_ptp), .rst(rst_ptp), .req_s(req_s), .tgt_sec(tgt_sec),
    .tgt_ns(tgt_ns), .stop_in(stop_q), .mode_in(mode_q),
    .cur_sec(cur_sec), .cur_ns(cur_ns), .ack_tgl(ack_tgl),
    .evt_tgl(evt_tgl), .pps_run(pps_run)
  );
endmodule

// File: tb/tgt_time_cmp_tb.sv
`timescale 1ns/1ps
module tgt_time_cmp_tb;
  logic        clk_bus = 1'b0, clk_ptp = 1'b0;
  logic        rst_bus = 1'b1, rst_ptp = 1'b1;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        roll_dec = 1'b0;
  logic [31:0] cur_sec = 32'd0;
  logic [30:0] cur_ns = 31'd0;
  logic        pps_run, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic mpps = 1'b0;

  tgt_time_cmp u_dut (
    .clk_bus(clk_bus), .rst_bus(rst_bus), .clk_ptp(clk_ptp), .rst_ptp(rst_ptp),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .roll_dec(roll_dec), .cur_sec(cur_sec), .cur_ns(cur_ns),
    .pps_run(pps_run), .irq(irq)
  );

  always #2.5 clk_bus = ~clk_bus;
  initial begin
    #1;
    forever #10 clk_ptp = ~clk_ptp;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_bus);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk_bus);
    bus_we = 1'b0;
  endtask

  task automatic bread(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk_bus);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk_bus);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk_bus);
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 200; i++) begin
      bread(2'd1, v);
      if (!v[31]) break;
    end
  endtask

  task automatic run_case(input int ts, input int tn, input int s0, input int n0,
                          input logic [1:0] cmd, input logic [1:0] mode,
                          input logic en, input bit w1c);
    logic [31:0] v;
    bit reached, has_irq, has_pps;
    has_irq = (mode != 2'd3);
    has_pps = mode[1];
    cur_sec = 32'(s0);
    cur_ns  = 31'(n0);
    bread(2'd3, v);
    bwrite(2'd0, 32'(ts));
    bwrite(2'd1, 32'(tn));
    bwrite(2'd2, (32'(en) << 8) | (32'(mode) << 4) | 32'(cmd));
    wait_idle();
    settle(20);
    reached = (s0 > ts) || (s0 == ts && n0 >= tn);
    if (!reached) begin
      chk("R4 early pps_run", 32'(pps_run), 32'(mpps));
      bread(2'd3, v);
      chk("R4 early status", 32'(v[0]), 32'd0);
      cur_sec = 32'(ts);
      cur_ns  = 31'(tn + 3);
      settle(20);
    end
    if (has_pps) mpps = (cmd == 2'd2);
    chk("R6 R7 pps_run after target", 32'(pps_run), 32'(mpps));
    chk("R10 irq pin", 32'(irq), 32'(has_irq && en));
    if (w1c) begin
      bwrite(2'd3, 32'd1);
      bread(2'd3, v);
      chk("R10 write-one clear", 32'(v[0]), 32'd0);
    end else begin
      bread(2'd3, v);
      chk("R5 status per mode", 32'(v[0]), 32'(has_irq));
      bread(2'd3, v);
      chk("R10 clear on read", 32'(v[0]), 32'd0);
    end
    cur_sec = 32'(ts - 1);
    settle(10);
    cur_sec = 32'(ts + 1);
    settle(20);
    bread(2'd3, v);
    chk("R9 no refire status", 32'(v[0]), 32'd0);
    chk("R9 no refire pps_run", 32'(pps_run), 32'(mpps));
  endtask

  initial begin
    repeat (150000) @(posedge clk_bus);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1..all actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int ones;
    settle(5);
    rst_bus = 1'b0;
    rst_ptp = 1'b0;
    settle(4);

    // R8 reset state
    bread(2'd0, v); chk("R8 sec reset", v, 32'd0);
    bread(2'd1, v); chk("R8 ns reset", v, 32'd0);
    bread(2'd2, v); chk("R8 ctrl reset", v, 32'd0);
    bread(2'd3, v); chk("R8 status reset", v, 32'd0);
    chk("R8 pps_run reset", 32'(pps_run), 32'd0);
    chk("R8 irq reset", 32'(irq), 32'd0);

    // R1 readback, busy bit not writable
    bwrite(2'd0, 32'hA5A5_0001);
    bread(2'd0, v); chk("R1 sec readback", v, 32'hA5A5_0001);
    bwrite(2'd1, 32'hFFFF_FFFF);
    bread(2'd1, v); chk("R1 ns readback busy bit", v, 32'h7FFF_FFFF);

    // R11 decimal rollover limit
    roll_dec = 1'b1;
    bwrite(2'd1, 32'd1_000_000_000);
    bread(2'd1, v); chk("R11 over limit ignored", v, 32'h7FFF_FFFF);
    bwrite(2'd1, 32'd999_999_999);
    bread(2'd1, v); chk("R11 limit accepted", v, 32'd999_999_999);
    roll_dec = 1'b0;
    bwrite(2'd1, 32'd1_000_000_000);
    bread(2'd1, v); chk("R11 binary mode accepted", v, 32'd1_000_000_000);

    // R2 commands 0 and 1 start nothing
    bwrite(2'd2, 32'd0);
    bread(2'd1, v); chk("R2 cmd0 no busy", 32'(v[31]), 32'd0);
    bwrite(2'd2, 32'd1);
    bread(2'd1, v); chk("R2 cmd1 no busy", 32'(v[31]), 32'd0);

    // R2 busy window, R3 writes dropped during it
    cur_sec = 32'd0;
    cur_ns  = 31'd0;
    bwrite(2'd2, 32'h0000_0002);
    bwrite(2'd1, 32'd777);
    bwrite(2'd0, 32'd5);
    bwrite(2'd2, 32'h0000_0130);
    bread(2'd1, v); chk("R2 busy set", v, 32'h8000_0000 | 32'd1_000_000_000);
    wait_idle();
    bread(2'd1, v); chk("R2 R3 busy clear ns kept", v, 32'd1_000_000_000);
    bread(2'd0, v); chk("R3 sec kept", v, 32'hA5A5_0001);
    bread(2'd2, v); chk("R3 ctrl kept", v, 32'd0);

    // R4..R10 sweep around the target
    for (int mode = 0; mode < 4; mode++)
      for (int cmd = 2; cmd < 4; cmd++)
        for (int ds = -1; ds <= 1; ds++)
          for (int dn = -1; dn <= 1; dn++)
            run_case(10, 500, 10 + ds, 500 + dn, 2'(cmd), 2'(mode),
                     logic'(ds != 1), bit'(dn == 1));

    // R10 event arriving while status is being cleared every cycle
    cur_sec = 32'd100;
    cur_ns  = 31'd0;
    bwrite(2'd0, 32'd10);
    bwrite(2'd1, 32'd0);
    bread(2'd3, v);
    bwrite(2'd2, 32'h0000_0102);
    ones = 0;
    @(negedge clk_bus);
    bus_re = 1'b1; bus_addr = 2'd3;
    repeat (60) begin
      @(negedge clk_bus);
      ones += int'(bus_rdata[0]);
    end
    bus_re = 1'b0;
    chk("R10 event vs clear seen once", 32'(ones), 32'd1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule